// File: doc/BRIEF.md
# Public Coefficient Octet Feeder

The feeder keeps a coefficient-serial multiplier supplied with one public coefficient per cycle without holding a whole polynomial. It stores at most nine 13-bit coefficients. Memory delivers coefficients in groups of eight, called octets. An octet comes either as a wide word of eight 13-bit lanes or as a narrow word of eight 10-bit lanes. Narrow lanes are zero-extended to 13 bits. In both formats lane k carries the coefficient of degree k within the octet, counted from the least significant end.

A start load puts an octet in the bottom eight entries and begins a polynomial. After that, every consume strobe retires the bottom coefficient and moves the rest down by one. When one coefficient is left, the next octet is written in one of two places. If no consume happens in the same cycle, it goes into the top eight entries, above the remaining coefficient. If a consume happens in the same cycle, it goes straight into the bottom eight entries. In either case the stream has no gap. The feeder requests each refill and counts octets. After the last coefficient of the 32nd octet has been consumed, it pulses `done`. Misuse is recorded in two sticky flags.

The controller has three states. `S_IDLE` moves to `S_RUN` on a start load. `S_RUN` stays in `S_RUN` on a start load (restart). It moves to `S_FINISH` when the last coefficient of the 32nd octet is consumed. `S_FINISH` lasts one cycle and drives `done`. From there it returns to `S_IDLE`, or to `S_RUN` on a start load.

Top module: `coef_octet_feeder`

## Requirements
- R1: After reset, `coef_out`, `coef_valid`, `refill_req`, `done`, `underflow` and `overrun` are all 0.
- R2: A start load takes priority over a consume or refill in the same cycle. It replaces the buffer with the new octet, and in the next cycle `coef_out` shows lane 0 with `coef_valid` high and eight coefficients held. The octet count restarts at one.
- R3: With `src_narrow`=1, lane k is `narrow_word[10k+9:10k]` with three zero bits above it. With `src_narrow`=0, lane k is `wide_word[13k+12:13k]`.
- R4: A consume strobe on a non-empty buffer removes the bottom coefficient, and the next coefficient appears on `coef_out` the following cycle. With no strobe and no load, the output is held.
- R5: A refill while running, with exactly one coefficient held and no consume, keeps that coefficient at the bottom and places lanes 0..7 above it (nine held).
- R6: A refill while running, with exactly one coefficient held and a consume in the same cycle, presents lane 0 of the new octet in the next cycle (eight held).
- R7: `refill_req` is high exactly when the state is `S_RUN`, fewer than 32 octets have been loaded, and at most two coefficients are held.
- R8: When the last coefficient of the 32nd octet is consumed, `done` is high for exactly the next cycle. At that point `coef_valid` is low and the state leaves `S_RUN`.
- R9: A consume strobe on an empty buffer, without a start load, sets `underflow`. The flag stays set until reset.
- R10: A refill while running, with more than one coefficient held or with all 32 octets already loaded, sets `overrun` until reset and is discarded. The held coefficients are unchanged.
- R11: A refill outside `S_RUN` is ignored and sets no flag. A refill while running with an empty buffer writes the octet at the bottom.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_load | input | 1 | Load octet at bottom and begin a polynomial |
| refill_load | input | 1 | Present the next octet of the running polynomial |
| src_narrow | input | 1 | 1 selects the narrow word, 0 the wide word |
| wide_word | input | 104 | Eight 13-bit lanes |
| narrow_word | input | 80 | Eight 10-bit lanes |
| consume | input | 1 | Retire the bottom coefficient |
| coef_out | output | 13 | Current (bottom) coefficient, 0 when empty |
| coef_valid | output | 1 | Buffer holds at least one coefficient |
| refill_req | output | 1 | Next octet wanted |
| done | output | 1 | One-cycle pulse after the final coefficient |
| underflow | output | 1 | Sticky: consume on empty buffer |
| overrun | output | 1 | Sticky: refill presented too early or beyond the last octet |

## Verification
The bench targets the seam between octets in both refill positions, because that is where an error shows up. A wrong top-write offset would repeat or drop the held coefficient. A wrong bottom-write choice would insert a bubble or swap order. It runs whole polynomials from both word formats with steady and irregular consume patterns. A bad padding mux would leak high bits into narrow lanes. An off-by-one octet counter would pulse `done` an octet early or late, or reject the final octet as an overrun. Early refills, refills after the last octet, refills while idle and consumes on an empty buffer check that the flags fire and that discarded words leave the coefficient stream untouched.

// File: rtl/octet_feeder_pkg.sv
package octet_feeder_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_RUN    = 2'd1,
        S_FINISH = 2'd2
    } feed_state_e;
endpackage

// File: rtl/octet_unpack.sv
module octet_unpack #(
    parameter int LANES = 8,
    parameter int CW    = 13,
    parameter int NW    = 10
) (
    input  logic                  src_narrow,
    input  logic [LANES*CW-1:0]   wide_word,
    input  logic [LANES*NW-1:0]   narrow_word,
    output logic [LANES*CW-1:0]   octet
);
    localparam int PAD = CW - NW;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign octet[k*CW +: CW] = src_narrow
            ? {{PAD{1'b0}}, narrow_word[k*NW +: NW]}
            : wide_word[k*CW +: CW];
    end
endmodule

// File: rtl/coef_shift_buffer.sv
module coef_shift_buffer #(
    parameter int LANES = 8,
    parameter int CW    = 13,
    parameter int DEPTH = LANES + 1,
    parameter int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_low,
    input  logic                load_high,
    input  logic                shift,
    input  logic [LANES*CW-1:0] octet,
    output logic [CW-1:0]       head,
    output logic [CNTW-1:0]     count
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [CW-1:0] q;
        logic [CW-1:0] low_val;
        logic [CW-1:0] high_val;
        logic [CW-1:0] shift_val;

        if (i < LANES) begin : g_low
            assign low_val = octet[i*CW +: CW];
        end else begin : g_low_pad
            assign low_val = '0;
        end

        if (i > 0) begin : g_high
            assign high_val = octet[(i-1)*CW +: CW];
        end else begin : g_high_keep
            assign high_val = q;
        end

        if (i < DEPTH - 1) begin : g_sh
            assign shift_val = g_ent[i+1].q;
        end else begin : g_sh_top
            assign shift_val = '0;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (load_low) begin
                q <= low_val;
            end else if (load_high) begin
                q <= high_val;
            end else if (shift) begin
                q <= shift_val;
            end
        end
    end

    assign head = g_ent[0].q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load_low) begin
            count <= CNTW'(LANES);
        end else if (load_high) begin
            count <= count + CNTW'(LANES);
        end else if (shift) begin
            count <= count - CNTW'(1);
        end
    end
endmodule

// File: rtl/feeder_ctrl.sv
module feeder_ctrl
    import octet_feeder_pkg::*;
#(
    parameter int OCTETS = 32,
    parameter int CNTW   = 4,
    parameter int OCTW   = $clog2(OCTETS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_load,
    input  logic            refill_load,
    input  logic            consume,
    input  logic [CNTW-1:0] count,
    output logic            load_low,
    output logic            load_high,
    output logic            shift,
    output logic            refill_req,
    output logic            done,
    output logic            underflow,
    output logic            overrun,
    output feed_state_e     state
);
    feed_state_e     state_nx;
    logic [OCTW-1:0] oct_cnt;
    logic            empty;
    logic            one_left;
    logic            last_octet;
    logic            shift_ok;
    logic            refill_ok;
    logic            ov_evt;
    logic            uf_evt;

    assign empty      = (count == '0);
    assign one_left   = (count == CNTW'(1));
    assign last_octet = (oct_cnt == OCTW'(OCTETS));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx   = state;
        refill_ok  = 1'b0;
        ov_evt     = 1'b0;
        shift_ok   = consume && !start_load && !empty;
        uf_evt     = consume && !start_load && empty;
        done       = 1'b0;
        refill_req = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start_load) state_nx = S_RUN;
            end
            S_RUN: begin
                refill_req = !last_octet && (count <= CNTW'(2));
                refill_ok  = refill_load && !start_load && (count <= CNTW'(1)) && !last_octet;
                ov_evt     = refill_load && !start_load && !refill_ok;
                if (!start_load && shift_ok && last_octet && one_left) begin
                    state_nx = S_FINISH;
                end
            end
            S_FINISH: begin
                done     = 1'b1;
                state_nx = start_load ? S_RUN : S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
        load_low  = start_load || (refill_ok && (empty || shift_ok));
        load_high = refill_ok && one_left && !shift_ok;
        shift     = shift_ok && !load_low;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oct_cnt   <= '0;
            underflow <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            if (start_load) begin
                oct_cnt <= OCTW'(1);
            end else if (refill_ok) begin
                oct_cnt <= oct_cnt + OCTW'(1);
            end
            if (uf_evt) underflow <= 1'b1;
            if (ov_evt) overrun   <= 1'b1;
        end
    end
endmodule

// File: rtl/coef_octet_feeder.sv
module coef_octet_feeder
    import octet_feeder_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int CW     = 13,
    parameter int NW     = 10,
    parameter int OCTETS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_load,
    input  logic                refill_load,
    input  logic                src_narrow,
    input  logic [LANES*CW-1:0] wide_word,
    input  logic [LANES*NW-1:0] narrow_word,
    input  logic                consume,
    output logic [CW-1:0]       coef_out,
    output logic                coef_valid,
    output logic                refill_req,
    output logic                done,
    output logic                underflow,
    output logic                overrun
);
    localparam int DEPTH = LANES + 1;
    localparam int CNTW  = $clog2(DEPTH + 1);
    localparam int OCTW  = $clog2(OCTETS + 1);

    logic [LANES*CW-1:0] octet;
    logic [CNTW-1:0]     buf_count;
    logic                load_low;
    logic                load_high;
    logic                shift;
    feed_state_e         feed_state;

    octet_unpack #(.LANES(LANES), .CW(CW), .NW(NW)) u_unpack (
        .src_narrow (src_narrow),
        .wide_word  (wide_word),
        .narrow_word(narrow_word),
        .octet      (octet)
    );

    coef_shift_buffer #(.LANES(LANES), .CW(CW), .DEPTH(DEPTH), .CNTW(CNTW)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_low (load_low),
        .load_high(load_high),
        .shift    (shift),
        .octet    (octet),
        .head     (coef_out),
        .count    (buf_count)
    );

    feeder_ctrl #(.OCTETS(OCTETS), .CNTW(CNTW), .OCTW(OCTW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_load (start_load),
        .refill_load(refill_load),
        .consume    (consume),
        .count      (buf_count),
        .load_low   (load_low),
        .load_high  (load_high),
        .shift      (shift),
        .refill_req (refill_req),
        .done       (done),
        .underflow  (underflow),
        .overrun    (overrun),
        .state      (feed_state)
    );

    assign coef_valid = (buf_count != '0);
endmodule

// File: rtl/coef_octet_feeder_checker.sv
module coef_octet_feeder_checker
    import octet_feeder_pkg::*;
#(
    parameter int LANES = 8,
    parameter int CW    = 13,
    parameter int CNTW  = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_load,
    input logic            refill_load,
    input logic            consume,
    input logic [CW-1:0]   coef_out,
    input logic            coef_valid,
    input logic            refill_req,
    input logic            done,
    input logic            underflow,
    input logic            overrun,
    input logic [CNTW-1:0] buf_count,
    input feed_state_e     feed_state
);
    a_r2_start_fills: assert property (@(posedge clk) disable iff (!rst_n)
        start_load |=> coef_valid && (buf_count == CNTW'(LANES)));

    a_r4_shift_one: assert property (@(posedge clk) disable iff (!rst_n)
        consume && !start_load && !refill_load && (buf_count != '0)
        |=> buf_count == $past(buf_count) - CNTW'(1));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !consume && !start_load && !refill_load |=> $stable(coef_out) && $stable(buf_count));

    a_r5_top_fill: assert property (@(posedge clk) disable iff (!rst_n)
        refill_load && refill_req && !start_load && !consume && (buf_count == CNTW'(1))
        |=> buf_count == CNTW'(LANES + 1));

    a_r7_req_window: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |-> (buf_count <= CNTW'(2)) && (feed_state == S_RUN));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !coef_valid);

    a_r9_uf_set: assert property (@(posedge clk) disable iff (!rst_n)
        consume && !start_load && !coef_valid |=> underflow);

    a_r9_uf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    a_r10_ov_set: assert property (@(posedge clk) disable iff (!rst_n)
        refill_load && !start_load && (feed_state == S_RUN) && (buf_count > CNTW'(1)) |=> overrun);

    a_r10_ov_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

bind coef_octet_feeder coef_octet_feeder_checker #(.LANES(LANES), .CW(CW), .CNTW(CNTW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_load (start_load),
    .refill_load(refill_load),
    .consume    (consume),
    .coef_out   (coef_out),
    .coef_valid (coef_valid),
    .refill_req (refill_req),
    .done       (done),
    .underflow  (underflow),
    .overrun    (overrun),
    .buf_count  (buf_count),
    .feed_state (feed_state)
);

// File: tb/coef_octet_feeder_test.sv
module coef_octet_feeder_test;
    localparam int LANES  = 8;
    localparam int CW     = 13;
    localparam int NW     = 10;
    localparam int OCTETS = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_load = 1'b0, refill_load = 1'b0, src_narrow = 1'b0, consume = 1'b0;
    logic [LANES*CW-1:0] wide_word = '0;
    logic [LANES*NW-1:0] narrow_word = '0;
    logic [CW-1:0] coef_out;
    logic coef_valid, refill_req, done, underflow, overrun;

    always #4 clk = ~clk;

    coef_octet_feeder #(.LANES(LANES), .CW(CW), .NW(NW), .OCTETS(OCTETS)) uut (
        .clk(clk), .rst_n(rst_n), .start_load(start_load), .refill_load(refill_load),
        .src_narrow(src_narrow), .wide_word(wide_word), .narrow_word(narrow_word),
        .consume(consume), .coef_out(coef_out), .coef_valid(coef_valid),
        .refill_req(refill_req), .done(done), .underflow(underflow), .overrun(overrun)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    string tag = "R1";

    int  m_q[$];
    bit  m_run, m_uf, m_ov, m_done;
    int  m_oct;

    function automatic int lane_val(int k, bit narrow, logic [LANES*CW-1:0] w, logic [LANES*NW-1:0] n);
        if (narrow) return int'(n[k*NW +: NW]);
        return int'(w[k*CW +: CW]);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk({tag, " coef_out"}, int'(coef_out), (m_q.size() > 0) ? m_q[0] : 0);
        chk({tag, " R2 coef_valid"}, int'(coef_valid), int'(m_q.size() > 0));
        chk({tag, " R7 refill_req"}, int'(refill_req), int'(m_run && m_oct < OCTETS && m_q.size() <= 2));
        chk({tag, " R8 done"}, int'(done), int'(m_done));
        chk({tag, " R9 underflow"}, int'(underflow), int'(m_uf));
        chk({tag, " R10 overrun"}, int'(overrun), int'(m_ov));
    endtask

    task automatic model_step(bit st, bit rf, bit cs, bit sel);
        int  sz;
        bit  sh_ok, rf_ok;
        sz = m_q.size();
        m_done = 1'b0;
        if (st) begin
            m_q.delete();
            for (int k = 0; k < LANES; k++) m_q.push_back(lane_val(k, sel, wide_word, narrow_word));
            m_oct = 1;
            m_run = 1'b1;
        end else begin
            sh_ok = cs && sz > 0;
            if (cs && sz == 0) m_uf = 1'b1;
            rf_ok = m_run && rf && sz <= 1 && m_oct < OCTETS;
            if (m_run && rf && !rf_ok) m_ov = 1'b1;
            if (m_run && sh_ok && sz == 1 && m_oct == OCTETS) begin
                m_run  = 1'b0;
                m_done = 1'b1;
            end
            if (sh_ok) void'(m_q.pop_front());
            if (rf_ok) begin
                for (int k = 0; k < LANES; k++) m_q.push_back(lane_val(k, sel, wide_word, narrow_word));
                m_oct++;
            end
        end
    endtask

    task automatic tick(bit st, bit rf, bit cs, bit sel);
        logic [127:0] r;
        r = {$urandom(), $urandom(), $urandom(), $urandom()};
        wide_word   = r[LANES*CW-1:0];
        r = {$urandom(), $urandom(), $urandom(), $urandom()};
        narrow_word = r[LANES*NW-1:0];
        start_load  = st;
        refill_load = rf;
        consume     = cs;
        src_narrow  = sel;
        @(posedge clk);
        model_step(st, rf, cs, sel);
        @(negedge clk);
        start_load = 1'b0; refill_load = 1'b0; consume = 1'b0;
        compare_all();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        m_q.delete();
        m_run = 0; m_uf = 0; m_ov = 0; m_done = 0; m_oct = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare_all();
    endtask

    // mode 0: steady consume, refill lands at bottom (R6)
    // mode 1: refill lands at top with no consume (R5)
    // mode 2: irregular consume
    task automatic stream(bit sel, int mode);
        bit rf, cs;
        tick(1'b1, 1'b0, 1'b0, sel);
        for (int n = 0; n < 2000 && m_run; n++) begin
            rf = (m_oct < OCTETS) && (m_q.size() <= 1);
            case (mode)
                0: cs = 1'b1;
                1: cs = !rf;
                default: cs = ($urandom_range(0, 2) != 0) && (m_q.size() > 0);
            endcase
            tick(1'b0, rf, cs, sel);
        end
        tick(1'b0, 1'b0, 1'b0, sel);
    endtask

    initial begin
        do_reset();
        tag = "R1";
        chk("R1 reset coef_out", int'(coef_out), 0);
        chk("R1 reset flags", int'({coef_valid, refill_req, done, underflow, overrun}), 0);

        tag = "R11";
        tick(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R11 idle refill no overrun", int'(overrun), 0);

        tag = "R6"; stream(1'b0, 0);
        tag = "R3"; stream(1'b1, 0);
        tag = "R5"; stream(1'b0, 1);
        tag = "R4"; stream(1'b1, 2);
        tag = "R8"; stream(1'b0, 2);

        tag = "R9";
        tick(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R9 underflow after consume on empty", int'(underflow), 1);
        tick(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 underflow sticky", int'(underflow), 1);

        do_reset();
        tag = "R10";
        tick(1'b1, 1'b0, 1'b0, 1'b1);
        tick(1'b0, 1'b0, 1'b1, 1'b1);
        tick(1'b0, 1'b1, 1'b0, 1'b1);
        chk("R10 early refill sets overrun", int'(overrun), 1);
        for (int n = 0; n < 6; n++) tick(1'b0, 1'b0, 1'b1, 1'b1);

        tag = "R11";
        tick(1'b0, 1'b0, 1'b1, 1'b1);
        tick(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R11 running with empty buffer", int'(coef_valid), 0);
        tick(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R11 refill on empty writes bottom", int'(coef_valid), 1);

        tag = "R2";
        for (int n = 0; n < 3; n++) tick(1'b0, 1'b0, 1'b1, 1'b0);
        tick(1'b1, 1'b1, 1'b1, 1'b0);
        chk("R2 restart holds eight", int'(m_q.size()), 8);

        do_reset();
        tag = "R10";
        tick(1'b1, 1'b0, 1'b0, 1'b0);
        for (int n = 0; n < 2000 && !(m_oct == OCTETS && m_q.size() == 1); n++) begin
            tick(1'b0, (m_oct < OCTETS) && (m_q.size() <= 1), 1'b1, 1'b0);
        end
        tick(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R10 refill past last octet sets overrun", int'(overrun), 1);
        tick(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8 final pulse over", int'(done), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule